// File: doc/BRIEF.md
# Byte-Accessed 16-bit Reload Timer

This block is a 16-bit down-counter with a reload latch. Software reaches it over an 8-bit register port that exposes a low byte and a high byte. A low-byte write only parks its data in a holding register. The matching high-byte write commits the full 16-bit word in one cycle. Depending on a mode input, that commit goes to the counter and the latch together, or to the latch alone. In the latch-only case the counter picks up the new value when it next wraps. Reads are made coherent by a snapshot: reading the high byte captures the low byte of the same counter value, and the low-byte read that follows returns that captured byte.

The counter moves only while the count-enable input is high. When it decrements past zero it reloads from the latch and raises a one-cycle wrap pulse. A PWM output can be enabled; it flips on every wrap and is forced low whenever counting is stopped. The intended PWM setup is latch-only writes, so that a new period takes effect cleanly at a wrap.

Top module: `reload_timer16`

## Requirements
- R1: A synchronous active-high reset clears the counter, the latch, the holding register and the read data, and drives the wrap pulse and the PWM output low.
- R2: A low-byte write (`byte_sel` = 0) changes neither the counter nor the latch. A later read of the counter returns the value it would have had without that write.
- R3: With `latch_only` = 0, a high-byte write (`byte_sel` = 1) loads {wdata, held low byte} into both the counter and the latch at that clock edge. That edge does not also decrement the counter.
- R4: With `latch_only` = 1, a high-byte write loads only the latch. The counter keeps counting and takes the new latch value at its next wrap.
- R5: The first high-byte write after reset loads both the counter and the latch, whatever the value of `latch_only`.
- R6: When `count_en` = 1 and the counter holds 0x0000, the next edge reloads the counter from the latch, and `uflow` is high for the cycle that follows that edge.
- R7: While `count_en` = 0, the counter holds its value apart from loads made by writes.
- R8: A latch-only high-byte write on the same edge as a wrap puts the written value into both the counter and the latch, with no decrement on that edge.
- R9: A high-byte read (`byte_sel` = 1) returns counter bits 15:8 on `rdata` one cycle later and saves counter bits 7:0. A following low-byte read returns the saved byte, even if the counter has moved since.
- R10: With `pwm_en` = 1 and `count_en` = 1, `pwm_out` toggles on each wrap. While either input is 0, `pwm_out` is driven low on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| byte_sel | input | 1 | 0 selects the low byte, 1 selects the high byte |
| wdata | input | 8 | Write data |
| latch_only | input | 1 | 1 sends high-byte commits to the latch only |
| count_en | input | 1 | Counting enable |
| pwm_en | input | 1 | Enables the toggle output |
| rdata | output | 8 | Registered read data |
| uflow | output | 1 | One-cycle wrap pulse |
| pwm_out | output | 1 | PWM toggle output |

## Verification
The bench goes after four corner cases.

- **Collision.** A latch-only commit lands on the very edge where the counter wraps. A design that reloads the old latch value here would show a stale period. A design that decrements the written value would read back one lower.
- **Read coherence.** A low-byte read follows a high-byte read while the counter keeps running. A design without the snapshot returns the already-decremented low byte.
- **First write after reset.** This write must load the counter even in latch-only mode. Getting it wrong leaves the counter at zero.
- **Reconfiguration.** Long random runs change modes and enables mid-count. A missed PWM clear on stop, or a lost wrap pulse, shows up against the cycle model.

// File: rtl/timer16_pkg.sv
package timer16_pkg;
  typedef enum logic {SEL_LO = 1'b0, SEL_HI = 1'b1} byte_sel_e;
endpackage

// File: rtl/timer16_wrport.sv
module timer16_wrport
  import timer16_pkg::*;
#(
  parameter int BUS_W = 8,
  localparam int CNT_W = 2 * BUS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             byte_sel,
  input  logic [BUS_W-1:0] wdata,
  input  logic             latch_only,
  output logic [BUS_W-1:0] hold_q,
  output logic             commit,
  output logic             force_load,
  output logic [CNT_W-1:0] commit_val
);
  logic first_q;

  assign commit     = wr_en && (byte_sel == SEL_HI);
  assign commit_val = {wdata, hold_q};
  assign force_load = first_q || !latch_only;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '0;
      first_q <= 1'b1;
    end else begin
      if (wr_en && (byte_sel == SEL_LO)) hold_q <= wdata;
      if (commit) first_q <= 1'b0;
    end
  end
endmodule

// File: rtl/timer16_core.sv
module timer16_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             count_en,
  input  logic             commit,
  input  logic             force_load,
  input  logic [CNT_W-1:0] commit_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] lat_q,
  output logic             wrap_now,
  output logic             uflow_q
);
  assign wrap_now = count_en && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      lat_q   <= '0;
      uflow_q <= 1'b0;
    end else begin
      uflow_q <= wrap_now;
      if (commit) lat_q <= commit_val;
      if (commit && (force_load || wrap_now)) cnt_q <= commit_val;
      else if (wrap_now)                      cnt_q <= lat_q;
      else if (count_en)                      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/timer16_rdport.sv
module timer16_rdport
  import timer16_pkg::*;
#(
  parameter int BUS_W = 8,
  localparam int CNT_W = 2 * BUS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic             byte_sel,
  input  logic [CNT_W-1:0] cnt_q,
  output logic [BUS_W-1:0] rdata
);
  logic [BUS_W-1:0] snap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      snap_q <= '0;
    end else if (rd_en) begin
      if (byte_sel == SEL_HI) begin
        rdata  <= cnt_q[CNT_W-1:BUS_W];
        snap_q <= cnt_q[BUS_W-1:0];
      end else begin
        rdata <= snap_q;
      end
    end
  end
endmodule

// File: rtl/timer16_pwm.sv
module timer16_pwm (
  input  logic clk,
  input  logic rst,
  input  logic pwm_en,
  input  logic count_en,
  input  logic wrap_now,
  output logic pwm_out
);
  always_ff @(posedge clk) begin
    if (rst || !pwm_en || !count_en) pwm_out <= 1'b0;
    else if (wrap_now)               pwm_out <= ~pwm_out;
  end
endmodule

// File: rtl/reload_timer16.sv
module reload_timer16 #(
  parameter int BUS_W = 8,
  localparam int CNT_W = 2 * BUS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             byte_sel,
  input  logic [BUS_W-1:0] wdata,
  input  logic             latch_only,
  input  logic             count_en,
  input  logic             pwm_en,
  output logic [BUS_W-1:0] rdata,
  output logic             uflow,
  output logic             pwm_out
);
  logic [BUS_W-1:0] hold_q;
  logic             commit;
  logic             force_load;
  logic [CNT_W-1:0] commit_val;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lat_q;
  logic             wrap_now;

  timer16_wrport #(.BUS_W(BUS_W)) u_wr (
    .clk(clk), .rst(rst), .wr_en(wr_en), .byte_sel(byte_sel), .wdata(wdata),
    .latch_only(latch_only), .hold_q(hold_q), .commit(commit),
    .force_load(force_load), .commit_val(commit_val)
  );

  timer16_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .count_en(count_en), .commit(commit),
    .force_load(force_load), .commit_val(commit_val), .cnt_q(cnt_q),
    .lat_q(lat_q), .wrap_now(wrap_now), .uflow_q(uflow)
  );

  timer16_rdport #(.BUS_W(BUS_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .byte_sel(byte_sel),
    .cnt_q(cnt_q), .rdata(rdata)
  );

  timer16_pwm u_pwm (
    .clk(clk), .rst(rst), .pwm_en(pwm_en), .count_en(count_en),
    .wrap_now(wrap_now), .pwm_out(pwm_out)
  );
endmodule

// File: rtl/reload_timer16_chk.sv
module reload_timer16_chk #(
  parameter int BUS_W = 8,
  localparam int CNT_W = 2 * BUS_W
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             byte_sel,
  input logic [BUS_W-1:0] wdata,
  input logic             latch_only,
  input logic             count_en,
  input logic [BUS_W-1:0] hold_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] lat_q,
  input logic             uflow,
  input logic             pwm_out
);
  logic hi_wr;
  logic started;
  assign hi_wr = wr_en && byte_sel;

  always_ff @(posedge clk) begin
    if (rst) started <= 1'b1;
    else     started <= started && !hi_wr;
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (cnt_q == '0) && (lat_q == '0) && !uflow && !pwm_out);

  a_r3_both_load: assert property (@(posedge clk) disable iff (rst)
    hi_wr && !latch_only |=> cnt_q == $past({wdata, hold_q}));

  a_r4_latch_only_keeps_count: assert property (@(posedge clk) disable iff (rst)
    hi_wr && latch_only && !started && !(count_en && cnt_q == '0)
    |=> cnt_q == ($past(count_en) ? $past(cnt_q) - 1'b1 : $past(cnt_q)));

  a_r6_wrap_reload: assert property (@(posedge clk) disable iff (rst)
    count_en && cnt_q == '0 && !hi_wr |=> uflow && cnt_q == $past(lat_q));

  a_r7_hold_when_stopped: assert property (@(posedge clk) disable iff (rst)
    !count_en && !hi_wr |=> $stable(cnt_q) && !uflow);

  a_r10_pwm_low_stopped: assert property (@(posedge clk) disable iff (rst)
    !count_en |=> !pwm_out);
endmodule

bind reload_timer16 reload_timer16_chk #(.BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .byte_sel(byte_sel), .wdata(wdata),
  .latch_only(latch_only), .count_en(count_en), .hold_q(hold_q),
  .cnt_q(cnt_q), .lat_q(lat_q), .uflow(uflow), .pwm_out(pwm_out)
);

// File: tb/sim_reload_timer16.sv
module sim_reload_timer16;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0, byte_sel = 1'b0;
  logic [7:0] wdata = '0;
  logic       latch_only = 1'b0, count_en = 1'b0, pwm_en = 1'b0;
  logic [7:0] rdata;
  logic       uflow, pwm_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // cycle model state, built from the requirements
  logic [15:0] m_cnt, m_lat;
  logic [7:0]  m_hold, m_snap, m_rdata;
  logic        m_uf, m_pwm, m_first;

  always #2.5 clk = ~clk;

  reload_timer16 u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .byte_sel(byte_sel),
    .wdata(wdata), .latch_only(latch_only), .count_en(count_en), .pwm_en(pwm_en),
    .rdata(rdata), .uflow(uflow), .pwm_out(pwm_out)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] next_cnt(input logic hi, input logic [15:0] val,
                                           input logic wrap);
    if (hi && (!latch_only || m_first || wrap)) return val;
    if (wrap)     return m_lat;
    if (count_en) return m_cnt - 16'd1;
    return m_cnt;
  endfunction

  task automatic model_reset();
    m_cnt = '0; m_lat = '0; m_hold = '0; m_snap = '0; m_rdata = '0;
    m_uf = 1'b0; m_pwm = 1'b0; m_first = 1'b1;
  endtask

  // drive at negedge, advance the model, compare at the next negedge
  task automatic cyc(input logic w, input logic r, input logic sel, input logic [7:0] d);
    logic hi, wrap;
    logic [15:0] val;
    wr_en = w; rd_en = r; byte_sel = sel; wdata = d;
    hi   = w && sel;
    wrap = count_en && (m_cnt == 16'd0);
    val  = {d, m_hold};
    if (r && sel)       begin m_rdata = m_cnt[15:8]; m_snap = m_cnt[7:0]; end
    else if (r && !sel)       m_rdata = m_snap;
    m_cnt = next_cnt(hi, val, wrap);
    if (hi) begin m_lat = val; m_first = 1'b0; end
    if (w && !sel) m_hold = d;
    m_uf = wrap;
    if (!pwm_en || !count_en) m_pwm = 1'b0;
    else if (wrap)            m_pwm = ~m_pwm;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R6 uflow", {15'd0, uflow}, {15'd0, m_uf});
    check("R10 pwm_out", {15'd0, pwm_out}, {15'd0, m_pwm});
    check("R9 rdata", {8'd0, rdata}, {8'd0, m_rdata});
  endtask

  task automatic wr16(input logic [15:0] v);
    cyc(1'b1, 1'b0, 1'b0, v[7:0]);
    cyc(1'b1, 1'b0, 1'b1, v[15:8]);
  endtask

  task automatic rd16(output logic [15:0] v);
    cyc(1'b0, 1'b1, 1'b1, 8'h00); v[15:8] = rdata;
    cyc(1'b0, 1'b1, 1'b0, 8'h00); v[7:0]  = rdata;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] v;
    void'($urandom(32'd20240607));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 uflow", {15'd0, uflow}, 16'd0);
    check("R1 pwm_out", {15'd0, pwm_out}, 16'd0);
    check("R1 rdata", {8'd0, rdata}, 16'd0);
    rd16(v); check("R1 counter", v, 16'h0000);

    // R5 first commit loads counter despite latch-only mode
    latch_only = 1'b1;
    wr16(16'h0005);
    rd16(v); check("R5 first write", v, 16'h0005);

    // R2 lone low-byte write is invisible; R7 stopped counter holds
    cyc(1'b1, 1'b0, 1'b0, 8'h77);
    rd16(v); check("R2 low only", v, 16'h0005);
    check("R7 hold", v, 16'h0005);

    // R3 both-load mode
    latch_only = 1'b0;
    wr16(16'h1234);
    rd16(v); check("R3 both load", v, 16'h1234);

    // R4 latch-only: counter takes new latch at the wrap
    wr16(16'h0003);
    latch_only = 1'b1;
    wr16(16'h0040);
    rd16(v); check("R4 counter kept", v, 16'h0003);
    count_en = 1'b1;
    repeat (4) cyc(1'b0, 1'b0, 1'b0, 8'h00);
    count_en = 1'b0;
    rd16(v); check("R4 reload at wrap", v, 16'h0040);

    // R8 collision: latch-only commit on the wrap edge
    latch_only = 1'b0;
    wr16(16'h0000);
    latch_only = 1'b1;
    cyc(1'b1, 1'b0, 1'b0, 8'h21);
    count_en = 1'b1;
    cyc(1'b1, 1'b0, 1'b1, 8'h00);
    count_en = 1'b0;
    check("R8 wrap pulse", {15'd0, uflow}, 16'd1);
    rd16(v); check("R8 collision load", v, 16'h0021);

    // R9 coherent read while counting
    latch_only = 1'b0;
    wr16(16'h0100);
    count_en = 1'b1;
    rd16(v); check("R9 snapshot", v, 16'h0100);
    count_en = 1'b0;

    // R10 PWM toggles on wraps, low when stopped
    wr16(16'h0001);
    pwm_en = 1'b1; count_en = 1'b1;
    repeat (2) cyc(1'b0, 1'b0, 1'b0, 8'h00);
    check("R10 toggle high", {15'd0, pwm_out}, 16'd1);
    repeat (2) cyc(1'b0, 1'b0, 1'b0, 8'h00);
    check("R10 toggle low", {15'd0, pwm_out}, 16'd0);
    repeat (2) cyc(1'b0, 1'b0, 1'b0, 8'h00);
    count_en = 1'b0;
    cyc(1'b0, 1'b0, 1'b0, 8'h00);
    check("R10 stopped low", {15'd0, pwm_out}, 16'd0);

    // random mix against the cycle model
    for (int i = 0; i < 4000; i++) begin
      int op;
      op = $urandom % 10;
      if ($urandom % 16 == 0) latch_only = $urandom % 2;
      if ($urandom % 12 == 0) count_en   = $urandom % 2;
      if ($urandom % 20 == 0) pwm_en     = $urandom % 2;
      case (op)
        0: cyc(1'b1, 1'b0, 1'b0, 8'($urandom % 24));
        1: cyc(1'b1, 1'b0, 1'b1, ($urandom % 4 == 0) ? 8'($urandom) : 8'h00);
        2: cyc(1'b0, 1'b1, 1'b1, 8'h00);
        3: cyc(1'b0, 1'b1, 1'b0, 8'h00);
        default: cyc(1'b0, 1'b0, 1'b0, 8'h00);
      endcase
    end
    count_en = 1'b0;
    cyc(1'b0, 1'b0, 1'b0, 8'h00);
    rd16(v); check("R4 R6 final counter", v, m_cnt);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule